// File: doc/BRIEF.md
# Pixel-Group Hit Timestamp Controller

This block sits in one inactive cell of a pixel sensor and keeps the hit history for a group of neighbouring pixels. A free-running 16-bit time code counts bunch-crossing ticks and is cleared at the start of each train. Every pixel sends the controller a comparator "fire" flag. On a trigger pulse, the controller copies the current time code into the next free slot of each pixel that fired and is not masked. The whole capture completes at the next clock edge.

Each pixel has four slots. A hit that arrives when all four are full is not stored. Instead it sets a sticky overflow bit for that pixel. Between trains, an external controller starts a readout pass and paces it with step pulses. The pass visits the pixels in ascending index order. Pixels that hold nothing are passed over without producing a word. Each occupied slot produces one parallel word containing the pixel index, the slot number, the timestamp and the pixel's overflow bit. There is no buffering: a word is valid for one cycle only. When the last pixel has been visited, a done flag rises and every pixel's storage is emptied for the next train.

Top module: `hit_stamp_ctrl`

## Requirements
- R1: The time code is cleared to 0 by `train_start_i`, which wins over `tick_i` in the same cycle. Otherwise it increases by one on each cycle with `tick_i` high.
- R2: On a cycle with `trigger_i` high while no readout is running, each pixel p with `fire_i[p]`=1 and `mask_i[p]`=0 that holds fewer than 4 entries stores the time code of that cycle in slot number equal to its entry count, and its count increases by one.
- R3: A capture to a pixel that already holds 4 entries stores nothing and sets that pixel's overflow bit. The bit stays set until the end of the next readout pass and appears as `out_ovf_o`=1 on every word of that pixel.
- R4: A pixel with `mask_i[p]`=1 never records a hit and never sets its overflow bit.
- R5: A readout pass emits one word per stored entry, ordered by ascending pixel index and, within a pixel, by slot 0 upward. A word is produced on a cycle when `ro_step_i` is high while the scan sits on a pixel that holds data. `out_valid_o` and the word fields appear one cycle after that step.
- R6: Pixels with no entries produce no words and use no step. `ro_step_i` has no effect while no pass is running.
- R7: `ro_start_i` while idle starts a pass and raises `ro_busy_o` from the next cycle. After the last pixel is handled, `ro_busy_o` falls and `ro_done_o` rises and stays high until the next start. All entry counts and overflow bits are cleared at that point, so an immediate second pass emits no words.
- R8: Triggers that arrive while a pass is running capture nothing.
- R9: A trigger in the same cycle as `ro_start_i` is captured, and its entries appear in the pass it starts.
- R10: After a synchronous reset, `out_valid_o`, `ro_busy_o` and `ro_done_o` are 0 and all pixels are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Bunch-crossing tick, advances the time code |
| train_start_i | input | 1 | Clears the time code |
| trigger_i | input | 1 | Capture request |
| fire_i | input | 2*HALF_GROUP | Comparator fire flag per pixel |
| mask_i | input | 2*HALF_GROUP | Per-pixel mask, 1 = never record |
| ro_start_i | input | 1 | Starts a readout pass |
| ro_step_i | input | 1 | Requests the next readout word |
| out_valid_o | output | 1 | Word strobe |
| out_pix_o | output | clog2(2*HALF_GROUP) | Pixel index of the word |
| out_slot_o | output | clog2(SLOTS) | Slot number of the word |
| out_ts_o | output | TS_W | Stored timestamp |
| out_ovf_o | output | 1 | Overflow bit of the pixel |
| ro_busy_o | output | 1 | Readout pass running |
| ro_done_o | output | 1 | Last pass finished, storage cleared |

## Verification
Capture and readout can coincide in two ways. A trigger can land on the same edge as the start of a pass, and triggers can keep arriving while the scan is walking the group. The bench fires every pixel on a trigger issued together with `ro_start_i` and requires those entries in that pass. It also fires every pixel repeatedly during gapped-step passes and requires the emitted word sequence to match the model exactly, with no extra word. A tick issued together with a train start checks the time code's clear priority through the timestamp stored by the trigger that follows.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;
  localparam int unsigned DEF_TS_W   = 16;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_HALF_GROUP = 8;

  typedef enum logic {SCAN_IDLE = 1'b0, SCAN_RUN = 1'b1} scan_state_e;
endpackage

// File: rtl/hit_time_counter.sv
module hit_time_counter #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            train_start_i,
  output logic [TS_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)                cnt_o <= '0;
    else if (train_start_i) cnt_o <= '0;
    else if (tick_i)        cnt_o <= cnt_o + TS_W'(1);
  end

  p_train_zero_r1: assert property (@(posedge clk) disable iff (rst)
    train_start_i |=> (cnt_o == '0));
  p_tick_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !train_start_i) |=> (cnt_o == TS_W'($past(cnt_o) + TS_W'(1))));
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !train_start_i) |=> $stable(cnt_o));
endmodule

// File: rtl/hit_pixel_slots.sv
module hit_pixel_slots #(
  parameter int unsigned TS_W  = 16,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [FILL_W-1:0] fill_o,
  output logic              ovf_o,
  output logic [TS_W-1:0]   rd_ts_o
);
  logic [TS_W-1:0] mem [SLOTS];
  logic            has_room;

  assign has_room = (fill_o < FILL_W'(SLOTS));

  always_ff @(posedge clk) begin
    if (wr_i && has_room) mem[fill_o[SLOT_W-1:0]] <= ts_i;
  end

  assign rd_ts_o = mem[rd_slot_i];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      fill_o <= '0;
      ovf_o  <= 1'b0;
    end else if (wr_i) begin
      if (has_room) fill_o <= fill_o + FILL_W'(1);
      else          ovf_o  <= 1'b1;
    end
  end

  p_fill_cap_r3: assert property (@(posedge clk) disable iff (rst)
    fill_o <= FILL_W'(SLOTS));
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_i) |=> ovf_o);
  p_fill_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !clr_i && has_room) |=> (fill_o == FILL_W'($past(fill_o) + FILL_W'(1))));
  p_ovf_only_full_r3: assert property (@(posedge clk) disable iff (rst)
    (!ovf_o && !clr_i && !(wr_i && !has_room)) |=> !ovf_o);
endmodule

// File: rtl/hit_readout_scan.sv
module hit_readout_scan
  import hit_stamp_pkg::*;
#(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned PIXELS = 16,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1),
  localparam int unsigned PIX_W  = $clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [FILL_W-1:0] cur_fill_i,
  input  logic [TS_W-1:0]   cur_ts_i,
  input  logic              cur_ovf_i,
  output logic [PIX_W-1:0]  ptr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              busy_o,
  output logic              clr_o,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [SLOT_W-1:0] wslot_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              ovf_o,
  output logic              done_o
);
  scan_state_e state;
  logic empty, emit, last_slot, last_pix, leave_pix;

  assign busy_o    = (state == SCAN_RUN);
  assign empty     = (cur_fill_i == '0);
  assign emit      = busy_o && !empty && step_i;
  assign last_slot = (FILL_W'(slot_o) == cur_fill_i - FILL_W'(1));
  assign last_pix  = (ptr_o == PIX_W'(PIXELS - 1));
  assign leave_pix = busy_o && (empty || (emit && last_slot));
  assign clr_o     = leave_pix && last_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SCAN_IDLE;
      ptr_o   <= '0;
      slot_o  <= '0;
      valid_o <= 1'b0;
      pix_o   <= '0;
      wslot_o <= '0;
      ts_o    <= '0;
      ovf_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= emit;
      if (emit) begin
        pix_o   <= ptr_o;
        wslot_o <= slot_o;
        ts_o    <= cur_ts_i;
        ovf_o   <= cur_ovf_i;
      end
      if (!busy_o) begin
        if (start_i) begin
          state  <= SCAN_RUN;
          ptr_o  <= '0;
          slot_o <= '0;
          done_o <= 1'b0;
        end
      end else if (leave_pix) begin
        slot_o <= '0;
        if (last_pix) begin
          state  <= SCAN_IDLE;
          done_o <= 1'b1;
        end else begin
          ptr_o <= ptr_o + PIX_W'(1);
        end
      end else if (emit) begin
        slot_o <= slot_o + SLOT_W'(1);
      end
    end
  end

  p_valid_after_step_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(step_i) && $past(busy_o)));
  p_empty_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && empty) |=> !valid_o);
  p_idle_silent_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !valid_o);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_done_on_finish_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && clr_o) |=> (done_o && !busy_o));
endmodule

// File: rtl/hit_stamp_ctrl.sv
module hit_stamp_ctrl
  import hit_stamp_pkg::*;
#(
  parameter int unsigned HALF_GROUP = DEF_HALF_GROUP,
  parameter int unsigned TS_W       = DEF_TS_W,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  localparam int unsigned PIXELS = 2 * HALF_GROUP,
  localparam int unsigned PIX_W  = $clog2(PIXELS),
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              train_start_i,
  input  logic              trigger_i,
  input  logic [PIXELS-1:0] fire_i,
  input  logic [PIXELS-1:0] mask_i,
  input  logic              ro_start_i,
  input  logic              ro_step_i,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_pix_o,
  output logic [SLOT_W-1:0] out_slot_o,
  output logic [TS_W-1:0]   out_ts_o,
  output logic              out_ovf_o,
  output logic              ro_busy_o,
  output logic              ro_done_o
);
  logic [TS_W-1:0]   now_ts;
  logic [PIX_W-1:0]  scan_ptr;
  logic [SLOT_W-1:0] scan_slot;
  logic              scan_busy, scan_clr;
  logic [FILL_W-1:0] fill_arr [PIXELS];
  logic [TS_W-1:0]   rdts_arr [PIXELS];
  logic [PIXELS-1:0] ovf_vec, wr_vec;

  hit_time_counter #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .train_start_i(train_start_i), .cnt_o(now_ts)
  );

  for (genvar g = 0; g < PIXELS; g++) begin : g_pix
    assign wr_vec[g] = trigger_i && fire_i[g] && !mask_i[g] && !scan_busy;

    hit_pixel_slots #(.TS_W(TS_W), .SLOTS(SLOTS)) u_slots (
      .clk(clk), .rst(rst), .wr_i(wr_vec[g]), .ts_i(now_ts),
      .clr_i(scan_clr), .rd_slot_i(scan_slot),
      .fill_o(fill_arr[g]), .ovf_o(ovf_vec[g]), .rd_ts_o(rdts_arr[g])
    );

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
      (mask_i[g] && !scan_clr) |=> ($stable(fill_arr[g]) && $stable(ovf_vec[g])));
    p_busy_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
      (scan_busy && !scan_clr) |=> ($stable(fill_arr[g]) && $stable(ovf_vec[g])));
    p_done_cleared_r7: assert property (@(posedge clk) disable iff (rst)
      (scan_busy && scan_clr) |=> (fill_arr[g] == '0 && !ovf_vec[g]));
  end

  hit_readout_scan #(.TS_W(TS_W), .SLOTS(SLOTS), .PIXELS(PIXELS)) u_scan (
    .clk(clk), .rst(rst), .start_i(ro_start_i), .step_i(ro_step_i),
    .cur_fill_i(fill_arr[scan_ptr]), .cur_ts_i(rdts_arr[scan_ptr]),
    .cur_ovf_i(ovf_vec[scan_ptr]),
    .ptr_o(scan_ptr), .slot_o(scan_slot), .busy_o(scan_busy), .clr_o(scan_clr),
    .valid_o(out_valid_o), .pix_o(out_pix_o), .wslot_o(out_slot_o),
    .ts_o(out_ts_o), .ovf_o(out_ovf_o), .done_o(ro_done_o)
  );

  assign ro_busy_o = scan_busy;

  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && ro_start_i) |=> ro_busy_o);
endmodule

// File: tb/hit_stamp_ctrl_tb_top.sv
module hit_stamp_ctrl_tb_top;
  localparam int P = 16;
  localparam int S = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, trn = 0, trig = 0, ro_start = 0, ro_step = 0;
  logic [P-1:0] fire = '0, mask = '0;
  logic out_valid, out_ovf, ro_busy, ro_done;
  logic [3:0] out_pix;
  logic [1:0] out_slot;
  logic [15:0] out_ts;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_time = 0;
  logic [15:0] m_ts [P][S];
  int m_cnt [P];
  bit m_ovf [P];
  bit ro_active = 0;

  int e_pix [64];
  int e_slot [64];
  logic [15:0] e_ts [64];
  bit e_ovf [64];
  int n_exp;

  always #5 clk = ~clk;

  hit_stamp_ctrl dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .train_start_i(trn), .trigger_i(trig),
    .fire_i(fire), .mask_i(mask), .ro_start_i(ro_start), .ro_step_i(ro_step),
    .out_valid_o(out_valid), .out_pix_o(out_pix), .out_slot_o(out_slot),
    .out_ts_o(out_ts), .out_ovf_o(out_ovf), .ro_busy_o(ro_busy), .ro_done_o(ro_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, return at next negedge
  task automatic cyc(input logic t_trn, t_tick, t_trig, input logic [P-1:0] t_fire,
                     input logic t_start, t_step);
    trn = t_trn; tick = t_tick; trig = t_trig; fire = t_fire;
    ro_start = t_start; ro_step = t_step;
    @(posedge clk);
    if (t_trig && !ro_active) begin
      for (int p = 0; p < P; p++) begin
        if (t_fire[p] && !mask[p]) begin
          if (m_cnt[p] < S) begin m_ts[p][m_cnt[p]] = m_time; m_cnt[p]++; end
          else m_ovf[p] = 1;
        end
      end
    end
    if (t_trn) m_time = 0;
    else if (t_tick) m_time = m_time + 16'd1;
    @(negedge clk);
    trn = 0; tick = 0; trig = 0; ro_start = 0; ro_step = 0;
  endtask

  task automatic run_readout(input int gap, input bit trig_in_pass, input bit trig_at_start);
    int got = 0;
    cyc(0, 0, trig_at_start, trig_at_start ? '1 : '0, 1, 0);
    ro_active = 1;
    n_exp = 0;
    for (int p = 0; p < P; p++)
      for (int s = 0; s < m_cnt[p]; s++) begin
        e_pix[n_exp] = p; e_slot[n_exp] = s; e_ts[n_exp] = m_ts[p][s];
        e_ovf[n_exp] = m_ovf[p]; n_exp++;
      end
    chk(ro_busy === 1'b1, "R7 busy after start", ro_busy, 1);
    for (int i = 0; i < 600; i++) begin
      bit stp = (gap == 0) ? 1'b1 : ((i % gap) != 0);
      bit tr  = trig_in_pass && (i % 4 == 1);
      cyc(0, (i % 2 == 0), tr, '1, 0, stp);
      if (out_valid) begin
        if (got < n_exp) begin
          chk(out_pix == 4'(e_pix[got]), "R5 word pixel", out_pix, e_pix[got]);
          chk(out_slot == 2'(e_slot[got]), "R5 word slot", out_slot, e_slot[got]);
          chk(out_ts == e_ts[got], "R2 word timestamp", out_ts, e_ts[got]);
          chk(out_ovf == e_ovf[got], "R3 word overflow", out_ovf, e_ovf[got]);
        end
        got++;
      end
      if (ro_done) break;
    end
    chk(got == n_exp, "R6/R8 word count", got, n_exp);
    chk(ro_done === 1'b1 && ro_busy === 1'b0, "R7 done raised", ro_done, 1);
    ro_active = 0;
    for (int p = 0; p < P; p++) begin m_cnt[p] = 0; m_ovf[p] = 0; end
    cyc(0, 0, 0, '0, 0, 1);
    chk(ro_done === 1'b1 && out_valid === 1'b0, "R6/R7 done held, idle step silent", out_valid, 0);
  endtask

  task automatic train_round(input logic [15:0] seed, input logic [P-1:0] m,
                             input int gap, input bit trig_in_pass);
    mask = m;
    cyc(1, 1, 0, '0, 0, 0);
    for (int k = 0; k < 7; k++) begin
      logic [P-1:0] f;
      for (int t = 0; t < (k % 3) + seed[1:0]; t++) cyc(0, 1, 0, '0, 0, 0);
      f = P'((seed * 16'(k + 3)) ^ (16'hA5C3 >> k)) | P'(16'h0008);
      cyc(0, 0, 1, f, 0, 0);
    end
    run_readout(gap, trig_in_pass, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int p = 0; p < P; p++) begin m_cnt[p] = 0; m_ovf[p] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid === 1'b0 && ro_busy === 1'b0 && ro_done === 1'b0,
        "R10 reset outputs", {out_valid, ro_busy, ro_done}, 0);
    cyc(0, 0, 0, '0, 0, 1);
    chk(out_valid === 1'b0, "R6 step while idle", out_valid, 0);
    // empty group after reset: no words at all
    run_readout(0, 0, 0);

    // R1 clear priority: train start with tick, then immediate trigger stores 0
    mask = '0;
    cyc(1, 1, 0, '0, 0, 0);
    cyc(0, 0, 1, P'(16'h0001), 0, 0);
    cyc(0, 1, 0, '0, 0, 0);
    cyc(0, 1, 1, P'(16'h0001), 0, 0);
    run_readout(0, 0, 0);

    // masked sweeps with overflow on pixel 3 (R2 R3 R4 R5)
    train_round(16'h1357, P'(16'h0041), 0, 0);
    train_round(16'h2468, P'(16'h8000), 3, 0);
    train_round(16'h0F0F, P'(16'hFFF7), 2, 0);
    train_round(16'h7001, '1, 0, 0);          // all masked: R4
    // triggers during pass (R8)
    train_round(16'h3C3C, P'(16'h0100), 3, 1);
    train_round(16'h5A5A, '0, 0, 1);
    // trigger together with start (R9)
    mask = P'(16'h0002);
    cyc(1, 1, 0, '0, 0, 0);
    repeat (5) cyc(0, 1, 0, '0, 0, 0);
    cyc(0, 0, 1, P'(16'h0F00), 0, 0);
    cyc(0, 1, 0, '0, 0, 0);
    run_readout(2, 0, 1);
    // second pass right after: storage emptied (R7)
    run_readout(0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule